// File: doc/BRIEF.md
# Multi-mode asynchronous serial port

This block is a full-duplex asynchronous serial transmitter and receiver with three framed modes. Mode 1 carries a 10-bit frame: a low start bit, eight data bits sent least significant bit first, and a high stop bit. Modes 2 and 3 carry an 11-bit frame. In these modes a ninth data bit, supplied with each written byte, sits between the eighth data bit and the stop bit. Software can use that ninth bit as a plain flag or as a parity bit.

Mode 2 takes its bit rate from the system clock: one bit lasts 16 clocks when the rate-doubling input is high and 32 clocks when it is low. Modes 1 and 3 take their rate from an external one-cycle tick. That tick runs at sixteen times the bit rate. The receiver oversamples each bit sixteen times and decides each bit by majority vote. A sticky framing-error flag records any stop bit received as 0. A single shared status output shows either that flag or the high mode-select bit, depending on a visibility control.

Top module: `sio_port`

## Requirements
- R1: With `mode_i` equal to 1 (or 0, which behaves as mode 1), `txd_o` sends a 10-bit frame. The frame is a 0 start bit, `wr_data_i` least significant bit first, and a 1 stop bit, each bit lasting 16 oversample ticks. When no frame is in progress the line idles at 1.
- R2: With `mode_i` equal to 2 or 3, the frame has 11 bits. The bit after the eighth data bit carries the `wr_bit9_i` value captured at the write.
- R3: In mode 2 an oversample tick occurs on every clock when `dbl_rate_i` is 1, so one bit lasts 16 clocks. When `dbl_rate_i` is 0 a tick occurs on every second clock, so one bit lasts 32 clocks. In modes 0, 1 and 3 each pulse of `baud_tick_i` is one oversample tick.
- R4: `tx_done_o` rises on the clock where the stop bit starts on `txd_o`. It stays high until `clr_tx_done_i`. If a set and a clear arrive on the same clock, the set wins.
- R5: A write (`wr_en_i`) that arrives while a frame is being sent is ignored. The frame in progress and the next received byte are unaffected.
- R6: A received byte appears on `rx_data_o`. In mode 1, `rx_bit9_o` takes the received stop bit. In modes 2 and 3 it takes the received ninth bit, and the stop bit is not stored.
- R7: The receiver starts on a 1-to-0 transition seen at an oversample tick. It samples each bit at ticks 7, 8 and 9 of the bit and takes the majority. A start bit whose majority is 1 is abandoned, so a glitch shorter than half a bit produces no byte, and a single-sample glitch inside a data bit does not change that bit.
- R8: `rx_done_o` rises when the stop bit's majority decision is made (tick 9 of the stop bit). It stays high until `clr_rx_done_i`, and the set wins over a clear on the same clock.
- R9: `fe_o` is set when the stop bit's majority is 0 and stays set until `clr_fe_i`.
- R10: `ctl_top_o` shows, one clock later, `fe_o` when `fe_show_i` is 1 and `mode_i[1]` when `fe_show_i` is 0.
- R11: During reset `txd_o` is 1 and `tx_done_o`, `rx_done_o`, `fe_o`, `rx_bit9_o`, `ctl_top_o` and `rx_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Frame and rate mode (0/1: 10-bit, external rate; 2: 11-bit, clock rate; 3: 11-bit, external rate) |
| dbl_rate_i | input | 1 | Mode 2 rate select: 1 gives clk/16 per bit, 0 gives clk/32 per bit |
| fe_show_i | input | 1 | Selects framing error (1) or mode high bit (0) onto `ctl_top_o` |
| baud_tick_i | input | 1 | External one-cycle oversample tick (16 per bit) |
| wr_en_i | input | 1 | Write strobe that starts a transmission |
| wr_data_i | input | 8 | Byte to transmit |
| wr_bit9_i | input | 1 | Ninth bit to transmit in modes 2 and 3 |
| clr_tx_done_i | input | 1 | Clears `tx_done_o` |
| clr_rx_done_i | input | 1 | Clears `rx_done_o` |
| clr_fe_i | input | 1 | Clears `fe_o` |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| rx_data_o | output | 8 | Last received byte |
| rx_bit9_o | output | 1 | Received ninth bit (modes 2, 3) or stop bit (mode 1) |
| tx_done_o | output | 1 | Sticky transmit-done flag |
| rx_done_o | output | 1 | Sticky receive-done flag |
| fe_o | output | 1 | Sticky framing-error flag |
| ctl_top_o | output | 1 | Shared status bit: framing error or mode high bit |

## Verification
The transmit line changes on the clock edge that accepts a write, so the start bit is visible at the first sample after that edge. Each later bit changes on the edge of the sixteenth oversample tick after the previous one, and `tx_done_o` rises on the same edge as the stop bit. On the receive side, a line change reaches the sampling logic after two synchronizer clocks. `rx_done_o`, `rx_data_o`, `rx_bit9_o` and `fe_o` all change on the edge of tick 9 of the stop bit, and `ctl_top_o` follows its source one clock later. A behavioural model in the bench counts those same ticks and registers, and every output is compared against it half a clock after each edge. Separate end-to-end checks cover the bit-time clock counts in mode 2, the values of each received byte, glitch rejection and the framing-error flag.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    MODE_ALT10 = 2'd0,
    MODE_VAR10 = 2'd1,
    MODE_FIX11 = 2'd2,
    MODE_VAR11 = 2'd3
  } sio_mode_e;

  // 11-bit frame modes carry a ninth data bit
  function automatic logic mode_long(input sio_mode_e m);
    return (m == MODE_FIX11) || (m == MODE_VAR11);
  endfunction

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/sio_rate.sv
module sio_rate
  import sio_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  sio_mode_e mode_i,
  input  logic      dbl_i,
  input  logic      baud_tick_i,
  output logic      os_tick_o
);
  logic half_q;

  always_ff @(posedge clk) begin
    if (rst) half_q <= 1'b0;
    else     half_q <= ~half_q;
  end

  always_comb begin
    if (mode_i == MODE_FIX11) os_tick_o = dbl_i | half_q;
    else                      os_tick_o = baud_tick_i;
  end

  // R3: in mode 2 at full rate the oversample tick never drops
  assert_fixed_rate_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_FIX11 && dbl_i) |-> os_tick_o);
  // R3: in mode 2 at half rate two ticks never arrive back to back
  assert_half_rate_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_FIX11 && !dbl_i && os_tick_o) |=>
      (!os_tick_o || mode_i != MODE_FIX11 || dbl_i));
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick_i,
  input  logic              long_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_bit9_i,
  input  logic              clr_done_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(OSR);
  localparam int LEFT_W  = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [LEFT_W-1:0]  left_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      txd_o  <= 1'b1;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      if (clr_done_i) done_o <= 1'b0;
      if (!busy_o) begin
        if (wr_en_i) begin
          sh_q   <= long_i ? {1'b1, wr_bit9_i, wr_data_i, 1'b0}
                           : {1'b1, 1'b1, wr_data_i, 1'b0};
          left_q <= long_i ? LEFT_W'(FRAME_W) : LEFT_W'(FRAME_W - 1);
          cnt_q  <= '0;
          busy_o <= 1'b1;
          txd_o  <= 1'b0;
        end
      end else if (os_tick_i) begin
        if (cnt_q == CNT_W'(OSR - 1)) begin
          cnt_q <= '0;
          if (left_q == LEFT_W'(1)) begin
            busy_o <= 1'b0;
            txd_o  <= 1'b1;
          end else begin
            sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
            left_q <= left_q - LEFT_W'(1);
            txd_o  <= sh_q[1];
            if (left_q == LEFT_W'(2)) done_o <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // R5: a write during a frame leaves the frame contents alone
  assert_ignore_busy_write_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && wr_en_i && !os_tick_i) |=> $stable(sh_q) && $stable(left_q));
  // R4: done rises together with the stop bit on the line
  assert_done_on_stop_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (txd_o && busy_o));
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick_i,
  input  logic              long_i,
  input  logic              rxd_i,
  input  logic              clr_done_i,
  input  logic              clr_fe_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              done_o,
  output logic              fe_o
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(OSR);
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int SMP_A   = OSR / 2 - 1;
  localparam int SMP_B   = OSR / 2;
  localparam int SMP_C   = OSR / 2 + 1;

  logic              s1_q, s2_q, prev_q, act_q, long_q, va_q, vb_q, b9_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              bit_now;
  logic [IDX_W-1:0]  last_idx;

  always_comb begin
    bit_now  = vote3(va_q, vb_q, s2_q);
    last_idx = long_q ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b1; s2_q <= 1'b1; prev_q <= 1'b1;
      act_q <= 1'b0; long_q <= 1'b0; va_q <= 1'b0; vb_q <= 1'b0; b9_q <= 1'b0;
      cnt_q <= '0; idx_q <= '0; sh_q <= '0;
      data_o <= '0; bit9_o <= 1'b0; done_o <= 1'b0; fe_o <= 1'b0;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
      if (clr_done_i) done_o <= 1'b0;
      if (clr_fe_i)   fe_o   <= 1'b0;
      if (os_tick_i) begin
        if (!act_q) begin
          prev_q <= s2_q;
          if (prev_q && !s2_q) begin
            act_q  <= 1'b1;
            cnt_q  <= '0;
            idx_q  <= '0;
            long_q <= long_i;
          end
        end else begin
          if (cnt_q == CNT_W'(OSR - 1)) begin
            cnt_q <= '0;
            idx_q <= idx_q + IDX_W'(1);
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
          if (cnt_q == CNT_W'(SMP_A)) va_q <= s2_q;
          if (cnt_q == CNT_W'(SMP_B)) vb_q <= s2_q;
          if (cnt_q == CNT_W'(SMP_C)) begin
            if (idx_q == '0) begin
              if (bit_now) begin
                act_q  <= 1'b0;
                prev_q <= s2_q;
              end
            end else if (idx_q == last_idx) begin
              act_q  <= 1'b0;
              prev_q <= s2_q;
              done_o <= 1'b1;
              data_o <= sh_q;
              bit9_o <= long_q ? b9_q : bit_now;
              if (!bit_now) fe_o <= 1'b1;
            end else if (idx_q <= IDX_W'(DATA_W)) begin
              sh_q <= {bit_now, sh_q[DATA_W-1:1]};
            end else begin
              b9_q <= bit_now;
            end
          end
        end
      end
    end
  end

  // R8: receive-done holds until cleared
  assert_rxdone_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !clr_done_i) |=> done_o);
  // R9: framing error holds until cleared
  assert_fe_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (fe_o && !clr_fe_i) |=> fe_o);
  // R9: a new framing error only appears with a completed frame
  assert_fe_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fe_o) |-> done_o);
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic              dbl_rate_i,
  input  logic              fe_show_i,
  input  logic              baud_tick_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_bit9_i,
  input  logic              clr_tx_done_i,
  input  logic              clr_rx_done_i,
  input  logic              clr_fe_i,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic              fe_o,
  output logic              ctl_top_o
);
  sio_mode_e mode_s;
  logic      os_tick, long_s, tx_busy, past_ok_q;

  assign mode_s = sio_mode_e'(mode_i);
  assign long_s = mode_long(mode_s);

  sio_rate u_rate (
    .clk(clk), .rst(rst), .mode_i(mode_s), .dbl_i(dbl_rate_i),
    .baud_tick_i(baud_tick_i), .os_tick_o(os_tick)
  );

  sio_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .os_tick_i(os_tick), .long_i(long_s),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .wr_bit9_i(wr_bit9_i),
    .clr_done_i(clr_tx_done_i), .txd_o(txd_o), .busy_o(tx_busy),
    .done_o(tx_done_o)
  );

  sio_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .os_tick_i(os_tick), .long_i(long_s),
    .rxd_i(rxd_i), .clr_done_i(clr_rx_done_i), .clr_fe_i(clr_fe_i),
    .data_o(rx_data_o), .bit9_o(rx_bit9_o), .done_o(rx_done_o), .fe_o(fe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_top_o <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      ctl_top_o <= fe_show_i ? fe_o : mode_i[1];
      past_ok_q <= 1'b1;
    end
  end

  // R10: shared status bit follows its selected source one clock later
  assert_ctl_top_R10: assert property (@(posedge clk) disable iff (rst)
    past_ok_q |-> (ctl_top_o == ($past(fe_show_i) ? $past(fe_o) : $past(mode_i[1]))));
  // R1: line rests high whenever no frame is being sent
  assert_idle_line_R1: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd_o);
endmodule

// File: tb/sio_port_tb.sv
module sio_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd1;
  logic       dbl = 1'b1, fe_show = 1'b0, baud_tick = 1'b0;
  logic       wr_en = 1'b0, wr_b9 = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       clr_tx = 1'b0, clr_rx = 1'b0, clr_fe = 1'b0;
  logic       loop = 1'b1, rxd_drv = 1'b1;
  logic       rxd_line;
  logic       txd, rx_b9, tx_done, rx_done, fe, ctl;
  logic [7:0] rx_data;

  int checks = 0, failures = 0, cyc = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rxd_line = loop ? txd : rxd_drv;

  sio_port u_dut (
    .clk(clk), .rst(rst), .mode_i(mode), .dbl_rate_i(dbl), .fe_show_i(fe_show),
    .baud_tick_i(baud_tick), .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_bit9_i(wr_b9),
    .clr_tx_done_i(clr_tx), .clr_rx_done_i(clr_rx), .clr_fe_i(clr_fe),
    .rxd_i(rxd_line), .txd_o(txd), .rx_data_o(rx_data), .rx_bit9_o(rx_b9),
    .tx_done_o(tx_done), .rx_done_o(rx_done), .fe_o(fe), .ctl_top_o(ctl)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_half, m_busy, m_txd, m_txdone;
  int m_tcnt;
  bit m_tq[$];
  bit m_s1, m_s2, m_prev, m_ract, m_rlong, m_rxdone, m_fe, m_b9, m_ctl;
  int m_rcnt, m_ridx;
  bit m_samp[$];
  bit m_rbits[$];
  logic [7:0] m_rdata;

  always @(posedge clk) begin
    bit os, v, fe_before;
    int votes;
    cyc++;
    if (rst) begin
      m_half = 0; m_busy = 0; m_txd = 1; m_txdone = 0; m_tcnt = 0; m_tq.delete();
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_ract = 0; m_rlong = 0; m_rxdone = 0;
      m_fe = 0; m_b9 = 0; m_ctl = 0; m_rcnt = 0; m_ridx = 0; m_rdata = 8'h00;
      m_samp.delete(); m_rbits.delete();
    end else begin
      os = (mode == 2'd2) ? (dbl || m_half) : baud_tick;
      fe_before = m_fe;
      m_half = !m_half;
      if (clr_tx) m_txdone = 0;
      if (!m_busy) begin
        if (wr_en) begin
          m_tq.delete();
          for (int i = 0; i < 8; i++) m_tq.push_back(wr_data[i]);
          if (mode[1]) m_tq.push_back(wr_b9);
          m_tq.push_back(1'b1);
          m_busy = 1; m_txd = 0; m_tcnt = 0;
        end
      end else if (os) begin
        if (m_tcnt == 15) begin
          m_tcnt = 0;
          if (m_tq.size() == 0) begin m_busy = 0; m_txd = 1; end
          else begin
            m_txd = m_tq.pop_front();
            if (m_tq.size() == 0) m_txdone = 1;
          end
        end else m_tcnt++;
      end
      if (clr_rx) m_rxdone = 0;
      if (clr_fe) m_fe = 0;
      if (os) begin
        if (!m_ract) begin
          if (m_prev && !m_s2) begin
            m_ract = 1; m_rcnt = 0; m_ridx = 0; m_rlong = mode[1];
            m_samp.delete(); m_rbits.delete();
          end
          m_prev = m_s2;
        end else begin
          if (m_rcnt >= 7 && m_rcnt <= 9) m_samp.push_back(m_s2);
          if (m_rcnt == 9) begin
            votes = 0;
            foreach (m_samp[i]) votes += int'(m_samp[i]);
            v = (votes >= 2);
            m_samp.delete();
            if (m_ridx == 0) begin
              if (v) begin m_ract = 0; m_prev = m_s2; end
            end else if (m_ridx == (m_rlong ? 10 : 9)) begin
              m_rxdone = 1;
              for (int i = 0; i < 8; i++) m_rdata[i] = m_rbits[i];
              m_b9 = m_rlong ? m_rbits[8] : v;
              if (!v) m_fe = 1;
              m_ract = 0; m_prev = m_s2;
            end else m_rbits.push_back(v);
          end
          if (m_rcnt == 15) begin m_rcnt = 0; m_ridx++; end else m_rcnt++;
        end
      end
      m_ctl = fe_show ? fe_before : mode[1];
      m_s2 = m_s1;
      m_s1 = rxd_line;
    end
  end

  // compare every output half a clock after each edge
  always @(negedge clk) begin
    if (!rst && !ended) begin
      chk(txd == m_txd, "R1/R2 txd", txd, m_txd);
      chk(tx_done == m_txdone, "R4 tx_done", tx_done, m_txdone);
      chk(rx_done == m_rxdone, "R8 rx_done", rx_done, m_rxdone);
      chk(rx_data == m_rdata, "R6 rx_data", rx_data, m_rdata);
      chk(rx_b9 == m_b9, "R6 rx_bit9", rx_b9, m_b9);
      chk(fe == m_fe, "R9 fe", fe, m_fe);
      chk(ctl == m_ctl, "R10 ctl_top", ctl, m_ctl);
    end
  end

  // external oversample tick every fourth clock
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      baud_tick = (k % 4 == 3);
      k++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > WATCHDOG && !ended) begin
      ended = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d, input logic b9);
    @(negedge clk); wr_en = 1; wr_data = d; wr_b9 = b9;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_tx = 1; clr_rx = 1; clr_fe = 1;
    @(negedge clk); clr_tx = 0; clr_rx = 0; clr_fe = 0;
  endtask

  task automatic wait_rx(input int limit, input string req);
    int n = 0;
    while (!rx_done && n < limit) begin @(negedge clk); n++; end
    chk(rx_done == 1'b1, req, rx_done, 1);
  endtask

  // raw frame at 16 clocks per bit (mode 2, full rate); glitch flips one clock of bit 3
  task automatic send_raw(input logic [7:0] d, input logic b9, input logic stop, input bit glitch);
    bit bits[$];
    bits.push_back(1'b0);
    for (int i = 0; i < 8; i++) bits.push_back(d[i]);
    bits.push_back(b9);
    bits.push_back(stop);
    foreach (bits[j]) begin
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        rxd_drv = (glitch && j == 3 && c == 8) ? !bits[j] : bits[j];
      end
    end
    @(negedge clk); rxd_drv = 1;
  endtask

  initial begin
    int n;
    tick(3);
    // R11: reset state
    chk(txd == 1'b1, "R11 txd", txd, 1);
    chk({tx_done, rx_done, fe, rx_b9, ctl} == 5'b0, "R11 flags", {tx_done, rx_done, fe, rx_b9, ctl}, 0);
    chk(rx_data == 8'h00, "R11 rx_data", rx_data, 0);
    rst = 0;

    // R1 + R5: mode 1 loopback, a second write mid-frame is ignored
    mode = 2'd1;
    write_byte(8'hA5, 1'b0);
    tick(100);
    write_byte(8'h3C, 1'b1);
    wait_rx(3000, "R8 mode1 rx_done");
    chk(rx_data == 8'hA5, "R1/R5 mode1 byte", rx_data, 8'hA5);
    chk(rx_b9 == 1'b1, "R6 mode1 stop captured", rx_b9, 1);
    chk(tx_done == 1'b1, "R4 tx_done set", tx_done, 1);
    tick(20);
    chk(rx_done == 1'b1, "R8 rx_done sticky", rx_done, 1);
    tick(100);
    clear_flags();
    chk(tx_done == 1'b0 && rx_done == 1'b0, "R4/R8 cleared", {tx_done, rx_done}, 0);

    // R2 + R3: mode 2 full rate, stop bit begins 160 clocks after the write edge
    mode = 2'd2; dbl = 1;
    tick(2);
    @(negedge clk); wr_en = 1; wr_data = 8'h96; wr_b9 = 1;
    @(negedge clk); wr_en = 0; n = 1;
    while (!tx_done && n < 2000) begin @(negedge clk); n++; end
    chk(n == 161, "R3 full-rate bit time", n, 161);
    wait_rx(500, "R8 mode2 rx_done");
    chk(rx_data == 8'h96 && rx_b9 == 1'b1, "R2/R6 mode2 ninth bit", {rx_b9, rx_data}, 9'h196);
    tick(20);
    clear_flags();

    // R3: mode 2 half rate
    dbl = 0;
    @(negedge clk); wr_en = 1; wr_data = 8'h0F; wr_b9 = 0;
    @(negedge clk); wr_en = 0; n = 1;
    while (!tx_done && n < 2000) begin @(negedge clk); n++; end
    chk(n >= 319 && n <= 322, "R3 half-rate bit time", n, 320);
    wait_rx(500, "R8 mode2 half rx_done");
    chk(rx_data == 8'h0F && rx_b9 == 1'b0, "R2/R6 mode2 ninth bit 0", {rx_b9, rx_data}, 9'h00F);
    tick(40);
    clear_flags();

    // R2/R6/R10: mode 3 on external tick
    mode = 2'd3; fe_show = 0;
    write_byte(8'hC3, 1'b1);
    chk(ctl == 1'b1, "R10 shows mode high bit", ctl, 1);
    wait_rx(4000, "R8 mode3 rx_done");
    chk(rx_data == 8'hC3 && rx_b9 == 1'b1, "R2/R6 mode3 ninth bit", {rx_b9, rx_data}, 9'h1C3);
    tick(100);
    clear_flags();

    // R1: mode 0 acts as mode 1
    mode = 2'd0;
    write_byte(8'h11, 1'b0);
    wait_rx(3000, "R8 mode0 rx_done");
    chk(rx_data == 8'h11 && rx_b9 == 1'b1, "R1 mode0 ten-bit frame", {rx_b9, rx_data}, 9'h111);
    tick(100);
    clear_flags();

    // R7: short start glitch is rejected
    loop = 0; mode = 2'd2; dbl = 1;
    tick(4);
    @(negedge clk); rxd_drv = 0;
    tick(3);
    rxd_drv = 1;
    tick(300);
    chk(rx_done == 1'b0, "R7 glitch no byte", rx_done, 0);
    chk(rx_data == 8'h11, "R7 data unchanged", rx_data, 8'h11);

    // R7: single-sample glitch inside a data bit
    send_raw(8'h5A, 1'b0, 1'b1, 1);
    tick(5);
    chk(rx_done == 1'b1, "R8 raw rx_done", rx_done, 1);
    chk(rx_data == 8'h5A && rx_b9 == 1'b0, "R7 vote keeps bit", {rx_b9, rx_data}, 9'h05A);
    chk(fe == 1'b0, "R9 no framing error", fe, 0);
    clear_flags();

    // R9/R10: framing error
    send_raw(8'h81, 1'b1, 1'b0, 0);
    tick(5);
    chk(fe == 1'b1, "R9 fe set", fe, 1);
    chk(rx_data == 8'h81 && rx_b9 == 1'b1, "R6 bad-stop byte", {rx_b9, rx_data}, 9'h181);
    fe_show = 1;
    tick(2);
    chk(ctl == 1'b1, "R10 shows fe", ctl, 1);
    fe_show = 0; mode = 2'd1;
    tick(2);
    chk(ctl == 1'b0, "R10 shows mode bit", ctl, 0);
    chk(fe == 1'b1, "R9 fe sticky", fe, 1);
    @(negedge clk); clr_fe = 1;
    @(negedge clk); clr_fe = 0;
    chk(fe == 1'b0, "R9 fe cleared", fe, 0);
    tick(5);

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule